// File: doc/BRIEF.md
# Serial Converter Conversion Sequencer

This block runs an external 12-bit successive-approximation converter that is started by one pulse on a start line and read over a serial clock and data pair. For each conversion it raises the start line for a programmed number of system clocks and then drops it. The converter begins converting on that falling edge. The block then waits for the conversion time of the selected mode and clocks in a 16-bit frame on its own serial clock. It returns the low 12 bits as an unsigned result with a one-cycle valid strobe. Before it raises the start line again, it keeps a settling interval after the read.

There are two conversion waits: a short one for the fast-sampling mode and a longer one for the mode in which the converter powers down between conversions. An overlapped mode reads the frame during the conversion that was just started. That frame holds the result of the previous conversion. The block then needs only an acquisition gap before the next start, which raises throughput. Every interval is a parameter counted in system clocks. The sequencing makes sure that a start falling edge, which clears the converter's output shift register, never lands inside a read.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cnv_start_o`, `sclk_o` and `data_valid_o` are low and `data_o` is zero.
- R2: Each start pulse keeps `cnv_start_o` high for exactly `START_HI` system clocks. This value must be kept below 6 µs worth of clocks so that the sleeping converter wakes correctly.
- R3: In fast-sampling mode (`sleep_mode_i` = 0, `overlap_read_i` = 0), the first rising edge of `sclk_o` comes exactly `CONV_FAST + SCLK_HALF` clocks after the falling edge of `cnv_start_o`.
- R4: In sleep mode (`sleep_mode_i` = 1, `overlap_read_i` = 0), that same distance is `CONV_SLEEP + SCLK_HALF` clocks.
- R5: A read is exactly 16 pulses of `sclk_o`. Each high and each low phase lasts `SCLK_HALF` clocks, and `sclk_o` is low outside a read.
- R6: `sdata_i` is sampled at each rising serial clock edge, most significant bit first. `data_o` takes the last 12 bits of the 16-bit frame, and the first four bits are discarded. `data_valid_o` is high for exactly one clock, one clock after the final falling edge of `sclk_o`.
- R7: When read after conversion and `run_i` stays high, the next start pulse rises exactly `QUIET + 1` clocks after the final falling edge of `sclk_o`.
- R8: In overlapped mode (`overlap_read_i` = 1), the first `sclk_o` rise comes `SCLK_HALF` clocks after the start falling edge, and the frame holds the previous conversion's result. When the frame is shorter than the conversion wait, the next start pulse rises exactly wait + `ACQ` clocks after that falling edge.
- R9: No falling edge of `cnv_start_o` happens while a read is in progress, and `sclk_o` is low while `cnv_start_o` is high.
- R10: `sleep_mode_i` and `overlap_read_i` are sampled only when a start pulse begins. A change during a conversion takes effect at the next conversion.
- R11: With `run_i` low, no start pulse begins. Dropping `run_i` lets the current conversion and its read finish, and then the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Keep converting while high |
| sleep_mode_i | input | 1 | Selects the long conversion wait of the power-down mode |
| overlap_read_i | input | 1 | Read the previous result during the current conversion |
| sdata_i | input | 1 | Serial data from the converter |
| cnv_start_o | output | 1 | Start pulse, conversion starts on its falling edge |
| sclk_o | output | 1 | Serial read clock |
| data_valid_o | output | 1 | One-cycle strobe for a new result |
| data_o | output | 12 | Unsigned conversion result |

## Verification
The bench builds the block with START_HI=3, CONV_FAST=80, CONV_SLEEP=120, SCLK_HALF=2, QUIET=5 and ACQ=9. With these values a full cycle is a few hundred clocks, so many conversions fit in one run. The 64-clock frame fits inside both conversion waits, so an overlapped read finishes before the converter's output register reloads. Because the sleep wait is 40 clocks longer than the fast one, a mode latched at the wrong moment shows up as an exact timing mismatch. A bench converter model resets its bit pointer on every start falling edge and puts random values in the four discarded frame bits.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int FRAME_LEN = 16;
  localparam int RESULT_W  = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_CONV,
    ST_READ,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
  parameter int SCLK_HALF = 5,
  parameter int FRAME_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic                 sdata,
  output logic                 sclk,
  output logic                 busy,
  output logic                 done,
  output logic [FRAME_LEN-1:0] word
);
  localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BW = $clog2(FRAME_LEN);

  logic [HW-1:0] hcnt;
  logic [BW-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      bits <= '0;
      sclk <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      word <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy <= 1'b1;
        hcnt <= '0;
        bits <= '0;
        sclk <= 1'b0;
      end else if (busy) begin
        if (hcnt == HW'(SCLK_HALF - 1)) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            word <= {word[FRAME_LEN-2:0], sdata};
          end else begin
            sclk <= 1'b0;
            if (bits == BW'(FRAME_LEN - 1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bits <= bits + 1'b1;
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int START_HI   = 4,
  parameter int CONV_FAST  = 1000,
  parameter int CONV_SLEEP = 1750,
  parameter int SCLK_HALF  = 7,
  parameter int QUIET      = 50,
  parameter int ACQ        = 188
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_i,
  input  logic                sleep_mode_i,
  input  logic                overlap_read_i,
  input  logic                sdata_i,
  output logic                cnv_start_o,
  output logic                sclk_o,
  output logic                data_valid_o,
  output logic [RESULT_W-1:0] data_o
);
  localparam int CW = $clog2(START_HI + CONV_FAST + CONV_SLEEP + QUIET + ACQ + 1);

  seq_state_t state, state_n;
  logic          cnv_n, begin_pulse;
  logic          sleep_q, ovl_q;
  logic          t_load, t_exp;
  logic [CW-1:0] t_val;
  logic          sh_go, sh_busy, sh_done;
  logic [FRAME_LEN-1:0] sh_word;

  adc_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  adc_seq_shifter #(.SCLK_HALF(SCLK_HALF), .FRAME_LEN(FRAME_LEN)) u_shift (
    .clk(clk), .rst(rst), .go(sh_go), .sdata(sdata_i),
    .sclk(sclk_o), .busy(sh_busy), .done(sh_done), .word(sh_word)
  );

  always_comb begin
    state_n     = state;
    cnv_n       = cnv_start_o;
    t_load      = 1'b0;
    t_val       = '0;
    sh_go       = 1'b0;
    begin_pulse = 1'b0;
    case (state)
      ST_IDLE: if (run_i) begin_pulse = 1'b1;
      ST_PULSE: if (t_exp) begin
        cnv_n   = 1'b0;
        state_n = ST_CONV;
        t_load  = 1'b1;
        t_val   = sleep_q ? CW'(CONV_SLEEP - 1) : CW'(CONV_FAST - 1);
        sh_go   = ovl_q;
      end
      ST_CONV: if (t_exp && !sh_busy) begin
        if (ovl_q) begin
          state_n = ST_GAP;
          t_load  = 1'b1;
          t_val   = CW'(ACQ - 1);
        end else begin
          state_n = ST_READ;
          sh_go   = 1'b1;
        end
      end
      ST_READ: if (sh_done) begin
        state_n = ST_GAP;
        t_load  = 1'b1;
        t_val   = CW'(QUIET - 1);
      end
      ST_GAP: if (t_exp) begin
        if (run_i) begin_pulse = 1'b1;
        else       state_n     = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
    if (begin_pulse) begin
      state_n = ST_PULSE;
      cnv_n   = 1'b1;
      t_load  = 1'b1;
      t_val   = CW'(START_HI - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnv_start_o  <= 1'b0;
      sleep_q      <= 1'b0;
      ovl_q        <= 1'b0;
      data_valid_o <= 1'b0;
      data_o       <= '0;
    end else begin
      state        <= state_n;
      cnv_start_o  <= cnv_n;
      data_valid_o <= sh_done;
      if (begin_pulse) begin
        sleep_q <= sleep_mode_i;
        ovl_q   <= overlap_read_i;
      end
      if (sh_done) data_o <= sh_word[RESULT_W-1:0];
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int START_HI = 4
) (
  input logic clk,
  input logic rst,
  input logic cnv,
  input logic sclk,
  input logic valid,
  input logic busy
);
  logic [15:0] hi_cnt;
  logic [7:0]  rise_cnt;
  logic        sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      rise_cnt <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= sclk;
      hi_cnt <= cnv ? hi_cnt + 1'b1 : '0;
      if (cnv)                 rise_cnt <= '0;
      else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cnv && !sclk && !valid));

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= 16'(START_HI));

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= 8'd16);

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  assert_no_read_across_start_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv) |-> !$past(busy));

  assert_sclk_low_in_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    cnv |-> !sclk);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.START_HI(START_HI)) u_chk (
  .clk(clk), .rst(rst), .cnv(cnv_start_o), .sclk(sclk_o),
  .valid(data_valid_o), .busy(sh_busy)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int P_HI = 3, P_FAST = 80, P_SLEEP = 120, P_HALF = 2, P_QUIET = 5, P_ACQ = 9;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, run = 1'b0, slp = 1'b0, ovl = 1'b0;
  logic sdata;
  logic cnv, sclk, valid;
  logic [11:0] dout;

  adc_seq_ctrl #(.START_HI(P_HI), .CONV_FAST(P_FAST), .CONV_SLEEP(P_SLEEP),
                 .SCLK_HALF(P_HALF), .QUIET(P_QUIET), .ACQ(P_ACQ)) u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .run_i(run), .sleep_mode_i(slp), .overlap_read_i(ovl),
    .sdata_i(sdata), .cnv_start_o(cnv), .sclk_o(sclk), .data_valid_o(valid), .data_o(dout)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_rise_delay(input bit s, input bit o);
    if (o) return P_HALF;
    return (s ? P_SLEEP : P_FAST) + P_HALF;
  endfunction

  function automatic int ovl_period(input bit s);
    return (s ? P_SLEEP : P_FAST) + P_ACQ;
  endfunction

  // converter model and monitor state
  logic lat_slp, lat_ovl;
  always @(posedge clk) begin
    lat_slp <= slp;
    lat_ovl <= ovl;
  end

  int cyc = 0, t_rise = 0, t_fall = 0, t_srise = 0, t_sfall = 0;
  int nrise = 0, bitidx = 16, conv_left = 0, n_valid = 0, n_starts = 0, n_falls = 0;
  int last_delay = 0;
  bit cnv_p = 0, sclk_p = 0, valid_p = 0, have_prev = 0, armed = 0;
  bit c_slp = 0, c_ovl = 0, run_dropped = 0;
  logic [15:0] frame_rd = 16'h0, pending = 16'h0;
  logic [11:0] exp_word = 12'h0;

  assign sdata = (bitidx < 16) ? frame_rd[15 - bitidx] : 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (conv_left > 0) begin
        conv_left--;
        if (conv_left == 0) frame_rd = pending;
      end
      if (cnv && !cnv_p) begin
        n_starts++;
        if (have_prev && !run_dropped) begin
          if (armed) chk(cyc - t_sfall == P_QUIET + 1, "R7 gap after read", cyc - t_sfall, P_QUIET + 1);
          if (c_ovl) chk(cyc - t_fall == ovl_period(c_slp), "R8 overlapped period", cyc - t_fall, ovl_period(c_slp));
        end
        armed = 0;
        run_dropped = 0;
        c_slp = lat_slp;
        c_ovl = lat_ovl;
        t_rise = cyc;
      end
      if (!cnv && cnv_p) begin
        chk(cyc - t_rise == P_HI, "R2 start width", cyc - t_rise, P_HI);
        t_fall = cyc;
        have_prev = 1;
        n_falls++;
        pending = 16'($urandom);
        conv_left = c_slp ? P_SLEEP : P_FAST;
        bitidx = 0;
        nrise = 0;
      end
      if (sclk && !sclk_p) begin
        chk(!cnv, "R9 sclk during start", cnv, 0);
        if (nrise == 0) begin
          exp_word = frame_rd[11:0];
          last_delay = cyc - t_fall;
          chk(last_delay == first_rise_delay(c_slp, c_ovl),
              c_ovl ? "R8 read start" : (c_slp ? "R4 sleep wait" : "R3 fast wait"),
              last_delay, first_rise_delay(c_slp, c_ovl));
        end else begin
          chk(cyc - t_sfall == P_HALF, "R5 low phase", cyc - t_sfall, P_HALF);
        end
        nrise++;
        t_srise = cyc;
      end
      if (!sclk && sclk_p) begin
        chk(cyc - t_srise == P_HALF, "R5 high phase", cyc - t_srise, P_HALF);
        t_sfall = cyc;
        bitidx++;
      end
      if (valid_p) chk(!valid, "R6 strobe width", valid, 0);
      if (valid) begin
        chk(cyc - t_sfall == 1, "R6 strobe timing", cyc - t_sfall, 1);
        chk(nrise == 16, "R5 pulse count", nrise, 16);
        chk(dout == exp_word, "R6 result word", dout, exp_word);
        n_valid++;
        armed = !c_ovl;
      end
      cnv_p = cnv;
      sclk_p = sclk;
      valid_p = valid;
    end
  end

  // watchdog
  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_valids(input int k);
    int tgt;
    tgt = n_valid + k;
    while (n_valid < tgt) step(1);
  endtask

  task automatic wait_fall();
    int f;
    f = n_falls;
    while (n_falls == f) step(1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(5);
    @(negedge clk); #1;
    chk(!cnv && !sclk && !valid, "R1 outputs in reset", {cnv, sclk, valid}, 0);
    chk(dout == 12'h0, "R1 data in reset", dout, 0);
    step(1);
    rst = 1'b0;
    step(1);
    @(negedge clk); #1;
    chk(!cnv && !sclk && !valid && dout == 0, "R1 first cycle after reset", {cnv, sclk, valid}, 0);
    step(20);
    chk(n_starts == 0, "R11 idle with run low", n_starts, 0);

    // directed: fast mode, then sleep mode
    run = 1'b1;
    wait_valids(3);
    slp = 1'b1;
    wait_valids(3);

    // R10: mode change in mid conversion must wait for the next pulse
    slp = 1'b0;
    wait_valids(1);
    wait_fall();
    slp = 1'b1;
    wait_valids(1);
    chk(last_delay == P_FAST + P_HALF, "R10 mode latched at pulse start", last_delay, P_FAST + P_HALF);
    wait_valids(1);
    chk(last_delay == P_SLEEP + P_HALF, "R10 new mode on next pulse", last_delay, P_SLEEP + P_HALF);

    // overlapped mode
    ovl = 1'b1;
    slp = 1'b0;
    wait_valids(4);

    // R11: dropping run finishes the cycle and stops
    wait_fall();
    run = 1'b0;
    run_dropped = 1;
    begin
      int s0, v0;
      s0 = n_starts;
      v0 = n_valid;
      step(500);
      chk(n_starts == s0, "R11 no pulse after run low", n_starts, s0);
      chk(n_valid == v0 + 1, "R11 current read completes", n_valid, v0 + 1);
    end
    run = 1'b1;

    // random mix
    for (int i = 0; i < 40; i++) begin
      slp = 1'($urandom);
      ovl = 1'($urandom);
      wait_valids(1 + int'($urandom_range(2)));
      if ($urandom_range(4) == 0) begin
        run = 1'b0;
        run_dropped = 1;
        step(500);
        run = 1'b1;
      end
    end

    run = 1'b0;
    run_dropped = 1;
    step(500);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule